// File: doc/BRIEF.md
# Programmable Serial CRC Engine with Input Queue

This block divides a bit stream by a generator polynomial of 1 to 16 bits and leaves the remainder in a 16-bit working register. Data words enter through a write port into an eight-entry first-in, first-out queue. While the run control is high and the queue holds data, the engine takes one bit per clock from the head word, starting at the most significant bit. After the sixteenth bit of a word, that word leaves the queue. Full and empty flags tell the caller when to stop writing and when to drop the run control.

The divider uses the augmented form. The caller loads a start value, streams the message, and then streams as many zero bits as the polynomial degree. The low degree bits of the working register then hold the remainder. The top coefficient of the polynomial is implied and is not stored. A link that sends the least significant bit first is served by bit-reversing each byte in software before the write. A receiver that streams the message with its CRC appended gets a zero remainder when no error has occurred.

Top module: `crc_engine`

## Requirements
- R1: `cfg_len` holds the polynomial degree minus one, so n = `cfg_len`+1 and, for example, 15 selects a 16-bit polynomial. `cfg_taps[n-1:0]` holds every coefficient below the implied leading 1. The remainder is `result[n-1:0]`, and the reader masks the bits above it.
- R2: Each bit step shifts the working register left by one and puts the incoming bit into bit 0. If the bit that was at position `cfg_len` before the shift was 1, the shifted value is then XORed with `cfg_taps`. If it was 0, the shift alone is applied.
- R3: While `go` is 1 and the queue is not empty, exactly one bit is processed on each clock. While `go` is 1 and the queue is empty, the working register and the bit position stay unchanged.
- R4: Each word is consumed starting at bit 15 and ending at bit 0. A word leaves the queue on the clock that consumes its bit 0. Words are processed in the order in which they were written.
- R5: `fifo_full` is 1 when 8 words are held, and `fifo_empty` is 1 when no word is held. A write while the queue is full is dropped and sets `overflow`, which stays at 1 until reset.
- R6: A write to the result register while `go` is 0 loads `res_wdata` into the working register on the next clock. The same write while `go` is 1 has no effect.
- R7: With a zero start value, `cfg_len`=3, `cfg_taps`=0x5 (generator 10101) and the single word 0x3270 (two leading zeros, the message 1100100111, then four zero bits), `result[3:0]` ends at 0x5.
- R8: Streaming a message, followed by the CRC computed over that message, through the divider from the same start value leaves a zero remainder.
- R9: After reset, `result` is 0, `fifo_empty` is 1, and `fifo_full` and `overflow` are 0.
- R10: When `go` is dropped in the middle of a word, the working register and the bit position hold their values. Raising `go` again continues from the next unconsumed bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 16 | Data word for the queue |
| go | input | 1 | Run control for the bit engine |
| cfg_len | input | 4 | Polynomial degree minus one |
| cfg_taps | input | 16 | Generator coefficients without the top one |
| res_wr | input | 1 | Load the working register (only while `go` is 0) |
| res_wdata | input | 16 | Start value to load |
| result | output | 16 | Working register / remainder |
| fifo_full | output | 1 | Queue holds 8 words |
| fifo_empty | output | 1 | Queue holds no word |
| overflow | output | 1 | Sticky flag: a write was dropped |

## Verification
The divider is tried with a 4-bit generator on the known vector and with the 16-bit generator 0x1021 from both an all-ones and a zero start value. It is also tried with an 8-bit generator whose zero bits sit in the low byte of the last word, which separates a correct per-degree feedback position from a fixed top-bit tap. A single word with only its top bit set is timed clock by clock to show that bit 15 goes in first and that the queue empties after exactly sixteen steps. Eight distinct words written to a full queue, plus a ninth that must be dropped, separate first-in, first-out order from any other order. Pausing in the middle of a word, running the engine on an empty queue, and loading the working register while running each show whether a state holds or gets corrupted. The receiver check, which streams the message followed by its own CRC, closes the loop back to zero.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int unsigned CRC_MAX_W      = 16;
  localparam int unsigned CRC_FIFO_DEPTH = 8;

  // width of an index able to address n items (at least one bit)
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // width of a counter able to hold the value n
  function automatic int unsigned cnt_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/crc_fifo.sv
module crc_fifo
  import crc_pkg::*;
#(
  parameter int unsigned W     = CRC_MAX_W,
  parameter int unsigned DEPTH = CRC_FIFO_DEPTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty,
  output logic         ovf
);

  localparam int unsigned AW = idx_w(DEPTH);
  localparam int unsigned CW = cnt_w(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, count_nxt;
  logic          push_ok, pop_ok;

  assign push_ok = push && (count != CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);

  always_comb begin
    count_nxt = count;
    if (push_ok && !pop_ok) count_nxt = count + 1'b1;
    if (!push_ok && pop_ok) count_nxt = count - 1'b1;
  end

  // storage without reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  assign head = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
      ovf   <= 1'b0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count_nxt;
      full  <= (count_nxt == CW'(DEPTH));
      empty <= (count_nxt == '0);
      if (push && !push_ok) ovf <= 1'b1;
    end
  end

  // R5: occupancy never exceeds the depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R5: a push into a full queue does not change the occupancy
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    push && full && !pop |=> count == $past(count));

  // R5: the overflow flag stays set until reset
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  // R4: a lone pop removes exactly one word
  p_pop_one_r4: assert property (@(posedge clk) disable iff (rst)
    pop && !empty && !push |=> count == $past(count) - 1'b1);

endmodule

// File: rtl/crc_seq.sv
module crc_seq
  import crc_pkg::*;
#(
  parameter int unsigned W = CRC_MAX_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic         fifo_empty,
  input  logic [W-1:0] head,
  output logic         step,
  output logic         bit_out,
  output logic         pop
);

  localparam int unsigned IW = idx_w(W);

  logic [IW-1:0] bit_idx;
  logic [IW-1:0] sel;

  assign step    = go && !fifo_empty;
  assign sel     = IW'(W - 1) - bit_idx;
  assign bit_out = head[sel];
  assign pop     = step && (bit_idx == IW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx <= '0;
    end else if (step) begin
      bit_idx <= (bit_idx == IW'(W - 1)) ? '0 : bit_idx + 1'b1;
    end
  end

  // R3: running on an empty queue leaves the bit position alone
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    go && fifo_empty |=> $stable(bit_idx));

  // R10: a paused engine keeps its place inside the word
  p_pause_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !go |=> $stable(bit_idx));

  // R3: each step moves exactly one bit forward
  p_one_bit_r3: assert property (@(posedge clk) disable iff (rst)
    step && (bit_idx != IW'(W - 1)) |=> bit_idx == $past(bit_idx) + 1'b1);

  // R4: after the last bit of a word the next word starts at its top bit
  p_word_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    pop |=> bit_idx == '0);

endmodule

// File: rtl/crc_lfsr.sv
module crc_lfsr
  import crc_pkg::*;
#(
  parameter int unsigned W = CRC_MAX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  input  logic                bit_in,
  input  logic [W-1:0]        taps,
  input  logic [idx_w(W)-1:0] len,
  input  logic                load,
  input  logic [W-1:0]        load_val,
  output logic [W-1:0]        wreg
);

  logic         top;
  logic [W-1:0] shifted;
  logic [W-1:0] nxt;

  assign top     = wreg[len];
  assign shifted = {wreg[W-2:0], bit_in};
  assign nxt     = top ? (shifted ^ taps) : shifted;

  always_ff @(posedge clk) begin
    if (rst) begin
      wreg <= '0;
    end else if (step) begin
      wreg <= nxt;
    end else if (load) begin
      wreg <= load_val;
    end
  end

  // R3: no step and no load keeps the register
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !step && !load |=> $stable(wreg));

  // R2: with a clear feedback bit the new bit lands in bit 0 untouched
  p_plain_shift_r2: assert property (@(posedge clk) disable iff (rst)
    step && !wreg[len] |=> wreg[0] == $past(bit_in));

  // R2: with a set feedback bit, bit 0 carries the lowest tap
  p_xor_shift_r2: assert property (@(posedge clk) disable iff (rst)
    step && wreg[len] |=> wreg[0] == ($past(bit_in) ^ $past(taps[0])));

  // R6: a load places the start value
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    load && !step |=> wreg == $past(load_val));

endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
#(
  parameter int unsigned W     = CRC_MAX_W,
  parameter int unsigned DEPTH = CRC_FIFO_DEPTH,
  localparam int unsigned LW   = idx_w(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          go,
  input  logic [LW-1:0] cfg_len,
  input  logic [W-1:0]  cfg_taps,
  input  logic          res_wr,
  input  logic [W-1:0]  res_wdata,
  output logic [W-1:0]  result,
  output logic          fifo_full,
  output logic          fifo_empty,
  output logic          overflow
);

  logic [W-1:0] head;
  logic         step, bit_s, pop, load;

  assign load = res_wr && !go;

  crc_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_en),
    .push_data (wr_data),
    .pop       (pop),
    .head      (head),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .ovf       (overflow)
  );

  crc_seq #(.W(W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .fifo_empty (fifo_empty),
    .head       (head),
    .step       (step),
    .bit_out    (bit_s),
    .pop        (pop)
  );

  crc_lfsr #(.W(W)) u_lfsr (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .bit_in   (bit_s),
    .taps     (cfg_taps),
    .len      (cfg_len),
    .load     (load),
    .load_val (res_wdata),
    .wreg     (result)
  );

  // R6: a result write while running on an empty queue changes nothing
  p_load_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    res_wr && go && fifo_empty |=> $stable(result));

  // R5: full and empty are never raised together
  p_flags_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));

endmodule

// File: tb/crc_engine_tb.sv
module crc_engine_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        go = 1'b0;
  logic [3:0]  cfg_len = '0;
  logic [15:0] cfg_taps = '0;
  logic        res_wr = 1'b0;
  logic [15:0] res_wdata = '0;
  logic [15:0] result;
  logic        fifo_full, fifo_empty, overflow;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] msg [16];

  always #2 clk = ~clk;

  crc_engine u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .go(go),
    .cfg_len(cfg_len), .cfg_taps(cfg_taps), .res_wr(res_wr),
    .res_wdata(res_wdata), .result(result), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .overflow(overflow)
  );

  function automatic logic [15:0] mask_of(input int len);
    logic [16:0] m;
    m = (17'd1 << (len + 1)) - 17'd1;
    return m[15:0];
  endfunction

  // bitwise augmented division, top bit of each word first
  function automatic logic [15:0] model(input logic [15:0] init, input logic [15:0] taps,
                                        input int len, input logic [15:0] w [16], input int n);
    logic [15:0] r;
    logic        t;
    r = init;
    for (int i = 0; i < n; i++) begin
      for (int b = 15; b >= 0; b--) begin
        t = r[len];
        r = {r[14:0], w[i][b]};
        if (t) r = r ^ taps;
      end
    end
    return r & mask_of(len);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setup(input int len, input logic [15:0] taps, input logic [15:0] init);
    @(negedge clk);
    go = 1'b0;
    cfg_len = 4'(len);
    cfg_taps = taps;
    res_wr = 1'b1;
    res_wdata = init;
    @(negedge clk);
    res_wr = 1'b0;
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_until_empty();
    go = 1'b1;
    do @(negedge clk); while (!fifo_empty);
    go = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 result", result, 16'h0000);
    chk("R9 empty", {15'd0, fifo_empty}, 16'd1);
    chk("R9 full", {15'd0, fifo_full}, 16'd0);
    chk("R9 overflow", {15'd0, overflow}, 16'd0);
  endtask

  task automatic t_vector();
    setup(3, 16'h0005, 16'h0000);
    push(16'h3270);
    run_until_empty();
    chk("R7 check vector", result & 16'h000F, 16'h0005);
    msg[0] = 16'h3270;
    chk("R2 vector model", result & mask_of(3), model(16'h0, 16'h5, 3, msg, 1));
  endtask

  task automatic t_ccitt();
    setup(15, 16'h1021, 16'hFFFF);
    msg[0] = 16'h8327; msg[1] = 16'h4915; msg[2] = 16'h0000;
    for (int i = 0; i < 3; i++) push(msg[i]);
    run_until_empty();
    chk("R1 16-bit poly", result, model(16'hFFFF, 16'h1021, 15, msg, 3));
  endtask

  task automatic t_byte_poly();
    setup(7, 16'h0007, 16'h0000);
    msg[0] = 16'h8327; msg[1] = 16'h4900;
    push(msg[0]); push(msg[1]);
    run_until_empty();
    chk("R1 8-bit poly masked", result & 16'h00FF, model(16'h0, 16'h0007, 7, msg, 2));
  endtask

  task automatic t_receiver();
    logic [15:0] c;
    setup(15, 16'h1021, 16'h0000);
    msg[0] = 16'h1234; msg[1] = 16'hABCD; msg[2] = 16'h0000;
    for (int i = 0; i < 3; i++) push(msg[i]);
    run_until_empty();
    c = model(16'h0, 16'h1021, 15, msg, 3);
    chk("R8 sender crc", result, c);
    setup(15, 16'h1021, 16'h0000);
    push(16'h1234); push(16'hABCD); push(c);
    run_until_empty();
    chk("R8 receiver zero", result, 16'h0000);
  endtask

  task automatic t_timing();
    setup(15, 16'h1021, 16'h0000);
    push(16'h8000);
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    chk("R4 top bit first", result, 16'h0001);
    repeat (14) @(negedge clk);
    chk("R3 not empty after 15", {15'd0, fifo_empty}, 16'd0);
    @(negedge clk);
    chk("R3 empty after 16", {15'd0, fifo_empty}, 16'd1);
    chk("R3 result after 16", result, 16'h8000);
    repeat (5) @(negedge clk);
    chk("R3 stall on empty", result, 16'h8000);
    go = 1'b0;
  endtask

  task automatic t_full();
    setup(15, 16'h8005, 16'h1D0F);
    for (int i = 0; i < 8; i++) begin
      msg[i] = 16'(16'h1111 * (i + 1) + i * 7);
      push(msg[i]);
    end
    chk("R5 full at 8", {15'd0, fifo_full}, 16'd1);
    chk("R5 overflow clear", {15'd0, overflow}, 16'd0);
    push(16'hFFFF);
    chk("R5 overflow set", {15'd0, overflow}, 16'd1);
    run_until_empty();
    chk("R4 order and drop", result, model(16'h1D0F, 16'h8005, 15, msg, 8));
    chk("R5 overflow sticky", {15'd0, overflow}, 16'd1);
    chk("R5 full cleared", {15'd0, fifo_full}, 16'd0);
  endtask

  task automatic t_pause_and_load();
    logic [15:0] held;
    setup(15, 16'h1021, 16'h0000);
    msg[0] = 16'hC3A5; msg[1] = 16'h5A3C;
    push(msg[0]); push(msg[1]);
    @(negedge clk);
    go = 1'b1;
    repeat (5) @(negedge clk);
    res_wr = 1'b1; res_wdata = 16'hDEAD;
    @(negedge clk);
    res_wr = 1'b0;
    repeat (3) @(negedge clk);
    go = 1'b0;
    @(negedge clk);
    held = result;
    repeat (4) @(negedge clk);
    chk("R10 paused hold", result, held);
    run_until_empty();
    chk("R10/R6 resumed result", result, model(16'h0, 16'h1021, 15, msg, 2));
    setup(15, 16'h1021, 16'h1234);
    chk("R6 load while idle", result, 16'h1234);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_vector();
    t_ccitt();
    t_byte_poly();
    t_receiver();
    t_timing();
    t_full();
    t_pause_and_load();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule